// File: doc/BRIEF.md
# Virtqueue Transport Register Block

This block is the device side of a memory-mapped virtqueue transport. A driver reaches it over a simple 32-bit register bus. Through it the driver identifies the device, takes part in the status handshake and negotiates feature words one page at a time. It also programs a small set of virtqueues through a shared queue-select register, rings notifications, acknowledges interrupts and reaches a 256-byte device configuration window. The device logic behind the block sees notifications as a one-cycle pulse with a queue index. It raises interrupt causes through a bit vector, reads the status and the negotiated driver features, and rewrites configuration words through a private port.

Only aligned 32-bit accesses exist, and the decoded region is 0x200 bytes. Per-queue registers are banked, so the queue index written at 0x030 picks the bank that the size, ready and address registers reach. Once a queue is marked ready, its layout is frozen until the driver clears the ready bit or resets the whole block by writing 0 to the status register.

Top module: `virtq_mmio_regs`

## Requirements
- R1: Reads at 0x000, 0x004, 0x008 and 0x00C return 0x74726976, VERSION, DEVICE_ID and VENDOR_ID. Writes to these offsets are ignored. Unmapped offsets and any address with bus_addr[1:0] nonzero read 0 and ignore writes.
- R2: An access is taken on a rising edge where bus_valid is 1 and bus_ready is 0. bus_ready is 1 for exactly the next cycle, with bus_rdata holding the read value. A write is visible to every later access.
- R3: A read at 0x010 returns bits [32*s+31:32*s] of DEV_FEATURES, where s is the last value written to 0x014. When s >= FEAT_WORDS the read returns 0.
- R4: A write at 0x020 stores into driver feature word t, where t is the last value written to 0x024. That word appears on drv_features[32*t+31:32*t] and reads back at 0x020. When t >= FEAT_WORDS the write is ignored.
- R5: The status register at 0x070 stores wdata[7:0], reads back in its low 8 bits and drives status_out. The bits are 0 acknowledge, 1 driver, 2 driver ready, 3 features accepted and 7 failed.
- R6: The registers at 0x038 (size, 16 bits), 0x044 (ready, bit 0) and 0x080/0x084, 0x090/0x094, 0x0A0/0x0A4 (descriptor, available and used address, low/high) reach the bank of the queue written at 0x030. q_ready_o[i] is the ready bit of queue i. With a select of NUM_Q or more these read 0 and ignore writes.
- R7: 0x034 reads Q_MAX while the selected queue is not ready. It reads 0 while the selected queue is ready or the select is out of range.
- R8: While the selected queue is ready, writes to its size and address registers are ignored. Its ready bit stays writable.
- R9: A write at 0x050 raises notify_valid for exactly the cycle in which bus_ready is 1, with notify_queue equal to wdata[15:0].
- R10: A cycle with irq_raise[i] high sets pending bit i. 0x060 reads the pending bits. A write at 0x064 clears exactly the pending bits set in wdata, and a raise in the same cycle wins. irq_out is the OR of the pending bits.
- R11: Words 0x100 to 0x1FC are 64 configuration words that the driver reads and writes. A cfg_dev_we cycle writes cfg_dev_wdata to word cfg_dev_idx and wins over a driver write in the same cycle. Each device write increments the generation counter read at 0x0FC, which starts at 0. Driver writes leave it unchanged.
- R12: A write of 0 in wdata[7:0] to 0x070 clears status, all driver feature words, every queue's size, ready and address fields, and all pending interrupts. The configuration words and the generation counter are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request, held until bus_ready |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte address in the register region |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | One-cycle completion strobe |
| bus_rdata | output | 32 | Read data, valid while bus_ready |
| cfg_dev_we | input | 1 | Device-side configuration word write |
| cfg_dev_idx | input | 6 | Word index for the device-side write |
| cfg_dev_wdata | input | 32 | Device-side configuration data |
| irq_raise | input | IRQ_BITS | Interrupt cause set strobes |
| irq_out | output | 1 | Any interrupt pending |
| notify_valid | output | 1 | Queue notification pulse |
| notify_queue | output | 16 | Notified queue index |
| status_out | output | 8 | Current device status byte |
| q_ready_o | output | NUM_Q | Per-queue ready bits |
| drv_features | output | 32*FEAT_WORDS | Driver feature words, word 0 lowest |

## Verification
Banking is tried by giving two queues different sizes and addresses and reading each back through the select register. This tells a correct bank index apart from one shared bank or a stale select. Locking is tried by setting ready on one queue and writing its fields, which separates ignored writes from writes that land in the wrong bank. Feature paging uses an in-range and an out-of-range selector on both feature directions. Interrupt acknowledge uses partial masks so that a clear-all or a clear-none fault shows. A soft reset issued while the configuration space holds data shows that only the listed state is cleared.

// File: rtl/vmm_pkg.sv
// Package: shared constants and types for the virtqueue transport block.
// Word indices are byte offsets divided by four; the region is 0x200 bytes.
package vmm_pkg;

    localparam int          ADDR_W    = 9;
    localparam int          WIDX_W    = ADDR_W - 2;
    localparam int          CFG_IDX_W = 6;
    localparam int          CFG_WORDS = 1 << CFG_IDX_W;
    localparam logic [31:0] MAGIC     = 32'h7472_6976;

    localparam logic [WIDX_W-1:0] W_MAGIC   = 7'd0;
    localparam logic [WIDX_W-1:0] W_VERSION = 7'd1;
    localparam logic [WIDX_W-1:0] W_DEVID   = 7'd2;
    localparam logic [WIDX_W-1:0] W_VENDOR  = 7'd3;
    localparam logic [WIDX_W-1:0] W_DFEAT   = 7'd4;
    localparam logic [WIDX_W-1:0] W_DFSEL   = 7'd5;
    localparam logic [WIDX_W-1:0] W_DRVF    = 7'd8;
    localparam logic [WIDX_W-1:0] W_DRVSEL  = 7'd9;
    localparam logic [WIDX_W-1:0] W_QSEL    = 7'd12;
    localparam logic [WIDX_W-1:0] W_QMAX    = 7'd13;
    localparam logic [WIDX_W-1:0] W_QSIZE   = 7'd14;
    localparam logic [WIDX_W-1:0] W_QRDY    = 7'd17;
    localparam logic [WIDX_W-1:0] W_NOTIFY  = 7'd20;
    localparam logic [WIDX_W-1:0] W_ISR     = 7'd24;
    localparam logic [WIDX_W-1:0] W_IACK    = 7'd25;
    localparam logic [WIDX_W-1:0] W_STATUS  = 7'd28;
    localparam logic [WIDX_W-1:0] W_DLO     = 7'd32;
    localparam logic [WIDX_W-1:0] W_DHI     = 7'd33;
    localparam logic [WIDX_W-1:0] W_ALO     = 7'd36;
    localparam logic [WIDX_W-1:0] W_AHI     = 7'd37;
    localparam logic [WIDX_W-1:0] W_ULO     = 7'd40;
    localparam logic [WIDX_W-1:0] W_UHI     = 7'd41;
    localparam logic [WIDX_W-1:0] W_GEN     = 7'd63;

    // Banked queue field targeted by an access; address fields are consecutive.
    typedef enum logic [3:0] {
        QR_NONE, QR_SIZE, QR_READY,
        QR_DLO, QR_DHI, QR_ALO, QR_AHI, QR_ULO, QR_UHI
    } qreg_e;

    localparam int Q_ADDR_REGS = 6;

endpackage

// File: rtl/vmm_feat.sv
// Feature paging: device feature words are a constant seen through a
// selector; driver feature words are stored through a second selector.
// Assumes selector values outside [0, FEAT_WORDS) select nothing.
module vmm_feat #(
    parameter int                         FEAT_WORDS   = 2,
    parameter logic [FEAT_WORDS*32-1:0]   DEV_FEATURES = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         soft_clr,
    input  logic                         dsel_we,
    input  logic                         drvsel_we,
    input  logic                         drv_we,
    input  logic [31:0]                  wdata,
    output logic [31:0]                  dsel,
    output logic [31:0]                  drvsel,
    output logic [31:0]                  dev_word,
    output logic [31:0]                  drv_word,
    output logic [FEAT_WORDS*32-1:0]     drv_flat
);
    localparam int FW = (FEAT_WORDS > 1) ? $clog2(FEAT_WORDS) : 1;

    logic [31:0] dev_arr [FEAT_WORDS];
    logic [31:0] drv_arr [FEAT_WORDS];

    // Selector registers keep their values across a soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsel   <= '0;
            drvsel <= '0;
        end else begin
            if (dsel_we)   dsel   <= wdata;
            if (drvsel_we) drvsel <= wdata;
        end
    end

    for (genvar g = 0; g < FEAT_WORDS; g++) begin : g_word
        logic [31:0] drv_r;

        assign dev_arr[g] = DEV_FEATURES[g*32 +: 32];
        assign drv_arr[g] = drv_r;
        assign drv_flat[g*32 +: 32] = drv_r;

        // Store one driver feature word when its page is selected.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_clr)
                drv_r <= '0;
            else if (drv_we && drvsel == 32'(g))
                drv_r <= wdata;
        end
    end

    // Page selection for both directions, zero when out of range.
    always_comb begin
        dev_word = '0;
        drv_word = '0;
        if (dsel < 32'(FEAT_WORDS))   dev_word = dev_arr[dsel[FW-1:0]];
        if (drvsel < 32'(FEAT_WORDS)) drv_word = drv_arr[drvsel[FW-1:0]];
    end

endmodule

// File: rtl/vmm_qbank.sv
// Queue banks: size, ready and six address words per queue, reached through
// a select value. Assumes NUM_Q >= 2; a select of NUM_Q or more hits nothing.
// Size and address writes are dropped while that queue is ready.
module vmm_qbank
    import vmm_pkg::*;
#(
    parameter int NUM_Q = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          soft_clr,
    input  logic [31:0]                   sel,
    input  logic                          wr_en,
    input  qreg_e                         wr_reg,
    input  logic [31:0]                   wdata,
    output logic                          sel_valid,
    output logic                          sel_ready,
    output logic [15:0]                   sel_size,
    output logic [Q_ADDR_REGS-1:0][31:0]  sel_addr,
    output logic [NUM_Q-1:0]              ready_vec
);
    localparam int QW = $clog2(NUM_Q);

    logic [15:0]                  size_a [NUM_Q];
    logic [Q_ADDR_REGS-1:0][31:0] addr_a [NUM_Q];
    logic [2:0]                   aidx;
    logic                         is_addr;

    // Which address word an address-field access targets.
    always_comb begin
        is_addr = (wr_reg >= QR_DLO) && (wr_reg <= QR_UHI);
        aidx    = 3'(int'(wr_reg) - int'(QR_DLO));
    end

    assign sel_valid = sel < 32'(NUM_Q);

    for (genvar g = 0; g < NUM_Q; g++) begin : g_q
        logic                         hit;
        logic                         rdy_r;
        logic [15:0]                  size_r;
        logic [Q_ADDR_REGS-1:0][31:0] addr_r;

        assign hit          = wr_en && sel_valid && (sel[QW-1:0] == QW'(g));
        assign ready_vec[g] = rdy_r;
        assign size_a[g]    = size_r;
        assign addr_a[g]    = addr_r;

        // Update one queue's fields, honouring the ready lock.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_clr) begin
                rdy_r  <= 1'b0;
                size_r <= '0;
                addr_r <= '0;
            end else if (hit) begin
                if (wr_reg == QR_READY)
                    rdy_r <= wdata[0];
                else if (!rdy_r && wr_reg == QR_SIZE)
                    size_r <= wdata[15:0];
                else if (!rdy_r && is_addr)
                    addr_r[aidx] <= wdata;
            end
        end
    end

    // Present the selected bank, zeros when the select is out of range.
    always_comb begin
        sel_ready = 1'b0;
        sel_size  = '0;
        sel_addr  = '0;
        if (sel_valid) begin
            sel_ready = ready_vec[sel[QW-1:0]];
            sel_size  = size_a[sel[QW-1:0]];
            sel_addr  = addr_a[sel[QW-1:0]];
        end
    end

endmodule

// File: rtl/vmm_cfgwin.sv
// Device configuration window: CFG_WORDS words written by the driver bus or
// by the device port (device wins), plus a generation counter that counts
// device-side writes only.
module vmm_cfgwin
    import vmm_pkg::*;
#(
    parameter int GEN_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [CFG_IDX_W-1:0] bus_idx,
    input  logic [31:0]          bus_wdata,
    input  logic                 dev_we,
    input  logic [CFG_IDX_W-1:0] dev_idx,
    input  logic [31:0]          dev_wdata,
    input  logic [CFG_IDX_W-1:0] rd_idx,
    output logic [31:0]          rd_word,
    output logic [GEN_W-1:0]     gen
);
    logic [31:0] mem [CFG_WORDS];

    // Word storage; the device port takes priority on a collision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CFG_WORDS; i++) mem[i] <= '0;
        end else if (dev_we) begin
            mem[dev_idx] <= dev_wdata;
        end else if (bus_we) begin
            mem[bus_idx] <= bus_wdata;
        end
    end

    // Generation count of device-side updates.
    always_ff @(posedge clk) begin
        if (!rst_n)      gen <= '0;
        else if (dev_we) gen <= gen + 1'b1;
    end

    assign rd_word = mem[rd_idx];

endmodule

// File: rtl/virtq_mmio_regs.sv
// Top of the virtqueue transport register block. Decodes the 32-bit register
// bus, holds status, interrupt and notify state, and muxes read data.
// Assumes aligned accesses and a requester that holds bus_valid until
// bus_ready and drops it in that cycle.
module virtq_mmio_regs
    import vmm_pkg::*;
#(
    parameter int                       NUM_Q        = 4,
    parameter int                       FEAT_WORDS   = 2,
    parameter int                       IRQ_BITS     = 2,
    parameter logic [31:0]              Q_MAX        = 32'd256,
    parameter logic [31:0]              VERSION      = 32'd2,
    parameter logic [31:0]              DEVICE_ID    = 32'd2,
    parameter logic [31:0]              VENDOR_ID    = 32'h0000_5A17,
    parameter logic [FEAT_WORDS*32-1:0] DEV_FEATURES = 64'h0000_0001_0000_0027
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_valid,
    input  logic                       bus_we,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic                       bus_ready,
    output logic [31:0]                bus_rdata,
    input  logic                       cfg_dev_we,
    input  logic [CFG_IDX_W-1:0]       cfg_dev_idx,
    input  logic [31:0]                cfg_dev_wdata,
    input  logic [IRQ_BITS-1:0]        irq_raise,
    output logic                       irq_out,
    output logic                       notify_valid,
    output logic [15:0]                notify_queue,
    output logic [7:0]                 status_out,
    output logic [NUM_Q-1:0]           q_ready_o,
    output logic [FEAT_WORDS*32-1:0]   drv_features
);
    logic [WIDX_W-1:0]            w;
    logic                         aligned;
    logic                         acc;
    logic                         wr;
    logic                         soft_clr;
    logic                         cfg_hit;
    qreg_e                        qreg;
    logic [31:0]                  qsel;
    logic [7:0]                   status_r;
    logic [IRQ_BITS-1:0]          pending;
    logic [31:0]                  rd_mux;

    logic [31:0]                  dsel, drvsel, dev_word, drv_word;
    logic                         q_sel_valid, q_sel_ready;
    logic [15:0]                  q_size;
    logic [Q_ADDR_REGS-1:0][31:0] q_addr;
    logic [31:0]                  cfg_word;
    logic [31:0]                  gen;

    assign w        = bus_addr[ADDR_W-1:2];
    assign aligned  = bus_addr[1:0] == 2'b00;
    assign acc      = bus_valid && !bus_ready;
    assign wr       = acc && bus_we && aligned;
    assign cfg_hit  = w[WIDX_W-1];
    assign soft_clr = wr && w == W_STATUS && bus_wdata[7:0] == 8'h00;

    // Map a word index onto a banked queue field.
    always_comb begin
        case (w)
            W_QSIZE: qreg = QR_SIZE;
            W_QRDY:  qreg = QR_READY;
            W_DLO:   qreg = QR_DLO;
            W_DHI:   qreg = QR_DHI;
            W_ALO:   qreg = QR_ALO;
            W_AHI:   qreg = QR_AHI;
            W_ULO:   qreg = QR_ULO;
            W_UHI:   qreg = QR_UHI;
            default: qreg = QR_NONE;
        endcase
    end

    vmm_feat #(
        .FEAT_WORDS   (FEAT_WORDS),
        .DEV_FEATURES (DEV_FEATURES)
    ) u_feat (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_clr  (soft_clr),
        .dsel_we   (wr && w == W_DFSEL),
        .drvsel_we (wr && w == W_DRVSEL),
        .drv_we    (wr && w == W_DRVF),
        .wdata     (bus_wdata),
        .dsel      (dsel),
        .drvsel    (drvsel),
        .dev_word  (dev_word),
        .drv_word  (drv_word),
        .drv_flat  (drv_features)
    );

    vmm_qbank #(
        .NUM_Q (NUM_Q)
    ) u_qbank (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_clr  (soft_clr),
        .sel       (qsel),
        .wr_en     (wr && qreg != QR_NONE),
        .wr_reg    (qreg),
        .wdata     (bus_wdata),
        .sel_valid (q_sel_valid),
        .sel_ready (q_sel_ready),
        .sel_size  (q_size),
        .sel_addr  (q_addr),
        .ready_vec (q_ready_o)
    );

    vmm_cfgwin #(
        .GEN_W (32)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (wr && cfg_hit),
        .bus_idx   (w[CFG_IDX_W-1:0]),
        .bus_wdata (bus_wdata),
        .dev_we    (cfg_dev_we),
        .dev_idx   (cfg_dev_idx),
        .dev_wdata (cfg_dev_wdata),
        .rd_idx    (w[CFG_IDX_W-1:0]),
        .rd_word   (cfg_word),
        .gen       (gen)
    );

    // Queue select register; survives a soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                  qsel <= '0;
        else if (wr && w == W_QSEL)  qsel <= bus_wdata;
    end

    // Status byte: stores the written value; a zero write also clears the rest.
    always_ff @(posedge clk) begin
        if (!rst_n)                   status_r <= '0;
        else if (wr && w == W_STATUS) status_r <= bus_wdata[7:0];
    end

    // Pending interrupt bits: raise sets, acknowledge mask clears, raise wins.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr)
            pending <= '0;
        else if (wr && w == W_IACK)
            pending <= (pending & ~bus_wdata[IRQ_BITS-1:0]) | irq_raise;
        else
            pending <= pending | irq_raise;
    end

    // Notify pulse aligned with the completion strobe of the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            notify_valid <= 1'b0;
            notify_queue <= '0;
        end else begin
            notify_valid <= wr && w == W_NOTIFY;
            if (wr && w == W_NOTIFY) notify_queue <= bus_wdata[15:0];
        end
    end

    // Read data selection; unmapped or misaligned offsets give zero.
    always_comb begin
        rd_mux = '0;
        if (aligned) begin
            if (cfg_hit) begin
                rd_mux = cfg_word;
            end else begin
                case (w)
                    W_MAGIC:   rd_mux = MAGIC;
                    W_VERSION: rd_mux = VERSION;
                    W_DEVID:   rd_mux = DEVICE_ID;
                    W_VENDOR:  rd_mux = VENDOR_ID;
                    W_DFEAT:   rd_mux = dev_word;
                    W_DFSEL:   rd_mux = dsel;
                    W_DRVF:    rd_mux = drv_word;
                    W_DRVSEL:  rd_mux = drvsel;
                    W_QSEL:    rd_mux = qsel;
                    W_QMAX:    rd_mux = (q_sel_valid && !q_sel_ready) ? Q_MAX : 32'd0;
                    W_QSIZE:   rd_mux = {16'd0, q_size};
                    W_QRDY:    rd_mux = {31'd0, q_sel_ready};
                    W_ISR:     rd_mux = {{(32-IRQ_BITS){1'b0}}, pending};
                    W_STATUS:  rd_mux = {24'd0, status_r};
                    W_DLO:     rd_mux = q_addr[0];
                    W_DHI:     rd_mux = q_addr[1];
                    W_ALO:     rd_mux = q_addr[2];
                    W_AHI:     rd_mux = q_addr[3];
                    W_ULO:     rd_mux = q_addr[4];
                    W_UHI:     rd_mux = q_addr[5];
                    W_GEN:     rd_mux = gen;
                    default:   rd_mux = '0;
                endcase
            end
        end
    end

    // Bus completion: one-cycle ready, read data captured at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ready <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ready <= acc;
            if (acc) bus_rdata <= bus_we ? 32'd0 : rd_mux;
        end
    end

    assign status_out = status_r;
    assign irq_out    = |pending;

endmodule

// File: rtl/vmm_regs_chk.sv
// Checker for virtq_mmio_regs: temporal properties on its ports only.
// Attached to every instance of the top through the bind at the end.
module vmm_regs_chk #(
    parameter int NUM_Q      = 4,
    parameter int FEAT_WORDS = 2,
    parameter int IRQ_BITS   = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_valid,
    input logic                      bus_we,
    input logic [8:0]                bus_addr,
    input logic [31:0]               bus_wdata,
    input logic                      bus_ready,
    input logic [31:0]               bus_rdata,
    input logic [IRQ_BITS-1:0]       irq_raise,
    input logic                      irq_out,
    input logic                      notify_valid,
    input logic [7:0]                status_out,
    input logic [NUM_Q-1:0]          q_ready_o,
    input logic [FEAT_WORDS*32-1:0]  drv_features
);
    logic take, soft_wr;
    assign take    = bus_valid && !bus_ready;
    assign soft_wr = take && bus_we && bus_addr == 9'h070 && bus_wdata[7:0] == 8'h00;

    p_ready_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

    p_ready_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> bus_ready);

    p_magic_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !bus_we && bus_addr == 9'h000) |=> bus_rdata == 32'h7472_6976);

    p_notify_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        notify_valid |=> !notify_valid);

    p_notify_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && bus_we && bus_addr == 9'h050) |=> (notify_valid && bus_ready));

    p_ack_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && bus_we && bus_addr == 9'h064 && (&bus_wdata[IRQ_BITS-1:0])
         && irq_raise == '0) |=> !irq_out);

    p_raise_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((|irq_raise) && !soft_wr) |=> irq_out);

    p_soft_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
        soft_wr |=> (status_out == 8'h00 && q_ready_o == '0
                     && drv_features == '0 && !irq_out));

endmodule

bind virtq_mmio_regs vmm_regs_chk #(
    .NUM_Q      (NUM_Q),
    .FEAT_WORDS (FEAT_WORDS),
    .IRQ_BITS   (IRQ_BITS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_valid    (bus_valid),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_ready    (bus_ready),
    .bus_rdata    (bus_rdata),
    .irq_raise    (irq_raise),
    .irq_out      (irq_out),
    .notify_valid (notify_valid),
    .status_out   (status_out),
    .q_ready_o    (q_ready_o),
    .drv_features (drv_features)
);

// File: tb/tb_virtq_mmio_regs.sv
// Scoreboard bench: read tasks queue expected words, a monitor on the
// falling edge pops and compares them when the completion strobe shows.
module tb_virtq_mmio_regs;

    localparam int          NUM_Q     = 4;
    localparam int          FEAT      = 2;
    localparam int          IRQB      = 2;
    localparam logic [31:0] QMAX      = 32'd256;
    localparam logic [31:0] VER       = 32'd2;
    localparam logic [31:0] DEVID     = 32'd2;
    localparam logic [31:0] VENID     = 32'h0000_5A17;
    localparam logic [63:0] DFEAT     = 64'h0000_0001_0000_0027;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_we = 1'b0;
    logic [8:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_ready;
    logic [31:0]       bus_rdata;
    logic              cfg_dev_we = 1'b0;
    logic [5:0]        cfg_dev_idx = '0;
    logic [31:0]       cfg_dev_wdata = '0;
    logic [IRQB-1:0]   irq_raise = '0;
    logic              irq_out;
    logic              notify_valid;
    logic [15:0]       notify_queue;
    logic [7:0]        status_out;
    logic [NUM_Q-1:0]  q_ready_o;
    logic [FEAT*32-1:0] drv_features;

    int    checks = 0;
    int    errors = 0;
    logic  mon_rd = 1'b0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    virtq_mmio_regs #(
        .NUM_Q (NUM_Q), .FEAT_WORDS (FEAT), .IRQ_BITS (IRQB), .Q_MAX (QMAX),
        .VERSION (VER), .DEVICE_ID (DEVID), .VENDOR_ID (VENID),
        .DEV_FEATURES (DFEAT)
    ) dut (
        .clk (clk), .rst_n (rst_n), .bus_valid (bus_valid), .bus_we (bus_we),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_ready (bus_ready),
        .bus_rdata (bus_rdata), .cfg_dev_we (cfg_dev_we),
        .cfg_dev_idx (cfg_dev_idx), .cfg_dev_wdata (cfg_dev_wdata),
        .irq_raise (irq_raise), .irq_out (irq_out),
        .notify_valid (notify_valid), .notify_queue (notify_queue),
        .status_out (status_out), .q_ready_o (q_ready_o),
        .drv_features (drv_features)
    );

    always #5 clk = ~clk;

    task automatic chk(input logic ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare each read completion against the scoreboard head.
    always @(negedge clk) begin
        if (mon_rd && bus_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "scoreboard underflow", 64'(bus_rdata), 64'd0);
            end else begin
                logic [31:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(bus_rdata == e, t, 64'(bus_rdata), 64'(e));
            end
        end
    end

    task automatic bus_wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [8:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a; mon_rd = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0;
        #1 mon_rd = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        chk(1'b0, "watchdog expired", 64'd0, 64'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 R5 R6 R10: reset state at the ports
        chk(bus_ready == 1'b0, "R2 ready after reset", 64'(bus_ready), 64'd0);
        chk(status_out == 8'h00, "R5 status after reset", 64'(status_out), 64'd0);
        chk(q_ready_o == '0, "R6 ready bits after reset", 64'(q_ready_o), 64'd0);
        chk(irq_out == 1'b0, "R10 irq after reset", 64'(irq_out), 64'd0);

        // R1: identification, unmapped, misaligned, read-only
        bus_rd(9'h000, 32'h7472_6976, "R1 magic");
        bus_rd(9'h004, VER, "R1 version");
        bus_rd(9'h008, DEVID, "R1 device id");
        bus_rd(9'h00C, VENID, "R1 vendor id");
        bus_rd(9'h018, 32'd0, "R1 unmapped");
        bus_wr(9'h008, 32'hFFFF_FFFF);
        bus_rd(9'h008, DEVID, "R1 read-only write ignored");
        bus_rd(9'h001, 32'd0, "R1 misaligned read");

        // R3: device feature paging
        bus_wr(9'h014, 32'd0);
        bus_rd(9'h010, DFEAT[31:0], "R3 feature page 0");
        bus_wr(9'h014, 32'd1);
        bus_rd(9'h010, DFEAT[63:32], "R3 feature page 1");
        bus_wr(9'h014, 32'd5);
        bus_rd(9'h010, 32'd0, "R3 feature page out of range");

        // R4: driver feature paging
        bus_wr(9'h024, 32'd1);
        bus_wr(9'h020, 32'hDEAD_0001);
        bus_wr(9'h024, 32'd0);
        bus_wr(9'h020, 32'h0000_0011);
        @(negedge clk);
        chk(drv_features == 64'hDEAD_0001_0000_0011, "R4 driver words",
            64'(drv_features), 64'hDEAD_0001_0000_0011);
        bus_rd(9'h020, 32'h0000_0011, "R4 driver word 0 readback");
        bus_wr(9'h024, 32'd7);
        bus_wr(9'h020, 32'hFFFF_FFFF);
        @(negedge clk);
        chk(drv_features == 64'hDEAD_0001_0000_0011, "R4 out-of-range select ignored",
            64'(drv_features), 64'hDEAD_0001_0000_0011);

        // R5: status byte
        bus_wr(9'h070, 32'h0000_000B);
        bus_rd(9'h070, 32'h0000_000B, "R5 status readback");
        chk(status_out == 8'h0B, "R5 status port", 64'(status_out), 64'h0B);
        bus_wr(9'h070, 32'h0000_01FF);
        bus_rd(9'h070, 32'h0000_00FF, "R5 status low byte only");

        // R6 R7: banking through the queue select
        bus_wr(9'h030, 32'd0);
        bus_wr(9'h038, 32'd128);
        bus_wr(9'h080, 32'h0000_1000);
        bus_wr(9'h030, 32'd1);
        bus_wr(9'h038, 32'd64);
        bus_wr(9'h080, 32'h0000_2000);
        bus_wr(9'h0A4, 32'h0000_0007);
        bus_wr(9'h030, 32'd0);
        bus_rd(9'h038, 32'd128, "R6 queue0 size");
        bus_rd(9'h080, 32'h0000_1000, "R6 queue0 desc low");
        bus_rd(9'h0A4, 32'd0, "R6 queue0 used high untouched");
        bus_rd(9'h034, QMAX, "R7 max size when not ready");
        bus_wr(9'h030, 32'd1);
        bus_rd(9'h038, 32'd64, "R6 queue1 size");
        bus_rd(9'h0A4, 32'h0000_0007, "R6 queue1 used high");

        // R8 R7: lock after ready
        bus_wr(9'h044, 32'd1);
        @(negedge clk);
        chk(q_ready_o == 4'b0010, "R6 ready bit of queue1", 64'(q_ready_o), 64'h2);
        bus_rd(9'h034, 32'd0, "R7 max size reads 0 when ready");
        bus_wr(9'h038, 32'd32);
        bus_wr(9'h080, 32'h0000_3000);
        bus_rd(9'h038, 32'd64, "R8 size write ignored while ready");
        bus_rd(9'h080, 32'h0000_2000, "R8 address write ignored while ready");
        bus_rd(9'h044, 32'd1, "R6 ready readback");

        // R6: select out of range
        bus_wr(9'h030, 32'd9);
        bus_wr(9'h044, 32'd1);
        bus_rd(9'h038, 32'd0, "R6 out-of-range size reads 0");
        bus_rd(9'h034, 32'd0, "R7 out-of-range max size 0");
        chk(q_ready_o == 4'b0010, "R6 out-of-range write ignored", 64'(q_ready_o), 64'h2);

        // R9: notify pulse
        bus_wr(9'h050, 32'h0001_0003);
        chk(notify_valid == 1'b1 && notify_queue == 16'd3, "R9 notify pulse",
            {47'd0, notify_valid, notify_queue}, {47'd0, 1'b1, 16'd3});
        @(negedge clk);
        chk(notify_valid == 1'b0, "R9 notify one cycle", 64'(notify_valid), 64'd0);

        // R10: interrupt raise and partial acknowledge
        @(negedge clk); irq_raise = 2'b11;
        @(negedge clk); irq_raise = 2'b00;
        chk(irq_out == 1'b1, "R10 irq after raise", 64'(irq_out), 64'd1);
        bus_rd(9'h060, 32'd3, "R10 pending both");
        bus_wr(9'h064, 32'd1);
        bus_rd(9'h060, 32'd2, "R10 ack clears bit0 only");
        bus_wr(9'h064, 32'd2);
        bus_rd(9'h060, 32'd0, "R10 ack clears bit1");
        chk(irq_out == 1'b0, "R10 irq cleared", 64'(irq_out), 64'd0);

        // R11: configuration window and generation
        bus_wr(9'h104, 32'h0000_CAFE);
        bus_rd(9'h104, 32'h0000_CAFE, "R11 driver config word");
        bus_rd(9'h0FC, 32'd0, "R11 generation unchanged by driver");
        @(negedge clk);
        cfg_dev_we = 1'b1; cfg_dev_idx = 6'd5; cfg_dev_wdata = 32'h0000_0055;
        @(negedge clk);
        cfg_dev_we = 1'b0;
        bus_rd(9'h114, 32'h0000_0055, "R11 device config word");
        bus_rd(9'h0FC, 32'd1, "R11 generation after device write");
        bus_wr(9'h1FC, 32'hA5A5_0001);
        bus_rd(9'h1FC, 32'hA5A5_0001, "R11 last config word");

        // R12: soft reset through a zero status write
        bus_wr(9'h070, 32'h0000_000F);
        @(negedge clk); irq_raise = 2'b01;
        @(negedge clk); irq_raise = 2'b00;
        bus_wr(9'h070, 32'h0000_0000);
        @(negedge clk);
        chk(status_out == 8'h00, "R12 status cleared", 64'(status_out), 64'd0);
        chk(q_ready_o == '0, "R12 ready bits cleared", 64'(q_ready_o), 64'd0);
        chk(drv_features == '0, "R12 driver features cleared", 64'(drv_features), 64'd0);
        chk(irq_out == 1'b0, "R12 interrupts cleared", 64'(irq_out), 64'd0);
        bus_wr(9'h030, 32'd1);
        bus_rd(9'h038, 32'd0, "R12 queue size cleared");
        bus_rd(9'h080, 32'd0, "R12 queue address cleared");
        bus_rd(9'h104, 32'h0000_CAFE, "R12 config word kept");
        bus_rd(9'h0FC, 32'd1, "R12 generation kept");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all reads completed", 64'(exp_q.size()), 64'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule